// File: doc/BRIEF.md
# Multicycle Shared-ALU CPU Datapath

This block is the datapath of a small 32-bit load/store processor. Each instruction runs over several clock cycles. Three kinds of hardware are reused across those cycles: one ALU, one memory that holds both code and data, and one register file. Source multiplexers and a set of holding registers make that reuse possible. The block supports arithmetic between registers, word load, word store and branch-if-equal.

The block has no sequencer. A controller, or a testbench, drives every select and enable on every cycle and reads back three things: the opcode and function fields of the held instruction, and the ALU zero flag. A load port writes words into the memory before or between instructions. Two debug outputs show the program counter and any chosen register.

Each clock edge captures a new value in four holding registers: the memory data register, the two register-file operand latches and the ALU result latch. The program counter and the instruction register change only when their enables are high.

Top module: `mc_datapath`

## Requirements
- R1: While rst_ni is low and after it is released, the program counter, the instruction register and all registers of the register file read zero.
- R2: The program counter loads only on an edge where pc_write_i is high. With pc_source_i = 0 it takes the combinational ALU result. With pc_source_i = 1 it takes the latched ALU result. Otherwise it holds its value.
- R3: The instruction register loads memory read data only on an edge where ir_write_i is high, and holds it otherwise. opcode_o is bits [31:26] of the held word and funct_o is bits [5:0].
- R4: ALU operand A is the program counter when alu_src_a_i = 0 and the A latch when it is 1. ALU operand B depends on alu_src_b_i:
  - 00 selects the B latch;
  - 01 selects the constant 4;
  - 10 selects the sign-extended bits [15:0] of the instruction;
  - 11 selects that sign-extended value shifted left by 2.
- R5: alu_op_i selects the ALU function: 00 add, 01 subtract, 10 bitwise AND, 11 bitwise OR. zero_o is high exactly when the ALU result is all zeros.
- R6: Every edge loads the A latch with the register named by bits [25:21] of the instruction register and the B latch with the register named by bits [20:16]. The same edge loads the result latch with the ALU result and the data register with the memory read data.
- R7: The memory byte address is the program counter when iord_i = 0 and the latched ALU result when it is 1. Bits [9:2] of that address select one of 256 words, and all other address bits are ignored.
- R8: When mem_write_i is high, an edge writes the B latch into the addressed word. When load_en_i is high, an edge writes load_data_i into word load_addr_i instead.
- R9: When mem_read_i is low, the memory read data is zero, so the instruction register and the data register capture zero.
- R10: The register write address is bits [20:16] of the instruction when reg_dst_i = 0 and bits [15:11] when it is 1. The write data is the latched ALU result when mem_to_reg_i = 0 and the data register when it is 1. A write happens on an edge where reg_write_i is high.
- R11: Register 0 always reads zero, and writes to it are dropped.
- R12: A register write takes effect at the clock edge. A read of the same register during the write cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_write_i | input | 1 | Program counter load enable |
| pc_source_i | input | 1 | Next PC: 0 ALU result, 1 latched ALU result |
| ir_write_i | input | 1 | Instruction register load enable |
| iord_i | input | 1 | Memory address: 0 PC, 1 latched ALU result |
| mem_read_i | input | 1 | Memory read enable |
| mem_write_i | input | 1 | Memory write enable |
| alu_src_a_i | input | 1 | ALU operand A select |
| alu_src_b_i | input | 2 | ALU operand B select |
| alu_op_i | input | 2 | ALU function |
| reg_dst_i | input | 1 | Register write address select |
| mem_to_reg_i | input | 1 | Register write data select |
| reg_write_i | input | 1 | Register write enable |
| load_en_i | input | 1 | Memory preload enable |
| load_addr_i | input | 8 | Memory preload word index |
| load_data_i | input | 32 | Memory preload data |
| dbg_reg_sel_i | input | 5 | Register shown on dbg_reg_data_o |
| opcode_o | output | 6 | Instruction bits [31:26] |
| funct_o | output | 6 | Instruction bits [5:0] |
| zero_o | output | 1 | ALU result is zero |
| pc_o | output | 32 | Program counter |
| dbg_reg_data_o | output | 32 | Content of the selected register |

## Verification
The bench uses the default parameters: a 32-bit word, 32 registers and 256 memory words. With these values every register can be compared with a bench model after each instruction, and the code and data regions both fit in the memory. The bench runs a long stream of generated instructions, one cycle at a time: register arithmetic with all four functions, loads, stores, and branches both taken and not taken. The loads and stores use positive and negative offsets; a negative offset wraps the address and tests the word selection by bits [9:2]. The writeback cycle is sampled before its edge to confirm that a read returns the old register value. Writes to register 0 are checked, and the read-enable gate is checked on its own.

// File: rtl/mc_dp_pkg.sv
`timescale 1ns/1ps
package mc_dp_pkg;
  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_OR  = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG    = 2'b00,
    SRCB_FOUR   = 2'b01,
    SRCB_IMM    = 2'b10,
    SRCB_IMM_SH = 2'b11
  } srcb_sel_e;

  // instruction field positions, decoded by the controller
  localparam int unsigned OPC_LSB = 26;
  localparam int unsigned RS_LSB  = 21;
  localparam int unsigned RT_LSB  = 16;
  localparam int unsigned RD_LSB  = 11;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned FLD_W   = 6;
  localparam int unsigned RIDX_W  = 5;
endpackage

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = opa_i + opb_i;
      ALU_SUB: res_o = opa_i - opb_i;
      ALU_AND: res_o = opa_i & opb_i;
      ALU_OR:  res_o = opa_i | opb_i;
      default: res_o = '0;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 32,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ra1_i,
  input  logic [AW-1:0]     ra2_i,
  input  logic [AW-1:0]     ra3_i,
  output logic [DATA_W-1:0] rd1_o,
  output logic [DATA_W-1:0] rd2_o,
  output logic [DATA_W-1:0] rd3_o,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  logic [DATA_W-1:0] wd_i
);
  logic [DATA_W-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      // entry 0 is never written
      for (int i = 1; i < NREGS; i++)
        if (we_i && wa_i == AW'(i)) regs_q[i] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
  assign rd3_o = (ra3_i == '0) ? '0 : regs_q[ra3_i];

  assert_write_lands_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs_q[$past(wa_i)] == $past(wd_i));

  assert_zero_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i == '0) |=> rd3_o == '0 || ra3_i != '0);
endmodule

// File: rtl/mc_unified_mem.sv
`timescale 1ns/1ps
module mc_unified_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 256,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic [AW-1:0]     idx_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              ld_en_i,
  input  logic [AW-1:0]     ld_idx_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (ld_en_i)   mem_q[ld_idx_i] <= ld_data_i;
    else if (we_i) mem_q[idx_i]    <= wd_i;
  end

  assign rdata_o = re_i ? mem_q[idx_i] : '0;
endmodule

// File: rtl/mc_datapath.sv
`timescale 1ns/1ps
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NREGS     = 32,
  parameter int unsigned MEM_WORDS = 256,
  localparam int unsigned REG_AW   = $clog2(NREGS),
  localparam int unsigned MEM_AW   = $clog2(MEM_WORDS),
  localparam int unsigned BYTE_OFS = $clog2(DATA_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pc_write_i,
  input  logic              pc_source_i,
  input  logic              ir_write_i,
  input  logic              iord_i,
  input  logic              mem_read_i,
  input  logic              mem_write_i,
  input  logic              alu_src_a_i,
  input  logic [1:0]        alu_src_b_i,
  input  logic [1:0]        alu_op_i,
  input  logic              reg_dst_i,
  input  logic              mem_to_reg_i,
  input  logic              reg_write_i,
  input  logic              load_en_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [REG_AW-1:0] dbg_reg_sel_i,
  output logic [FLD_W-1:0]  opcode_o,
  output logic [FLD_W-1:0]  funct_o,
  output logic              zero_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] dbg_reg_data_o
);
  logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [DATA_W-1:0] mem_addr, mem_rdata;
  logic [DATA_W-1:0] imm_ext, imm_sh;
  logic [DATA_W-1:0] alu_opa, alu_opb, alu_res;
  logic [DATA_W-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, rf_wa;
  logic              unused_bits;

  assign rs_idx = ir_q[RS_LSB +: REG_AW];
  assign rt_idx = ir_q[RT_LSB +: REG_AW];
  assign rd_idx = ir_q[RD_LSB +: REG_AW];

  assign imm_ext = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh  = {imm_ext[DATA_W-3:0], 2'b00};

  // operand selection
  assign alu_opa = alu_src_a_i ? a_q : pc_q;

  always_comb begin
    unique case (srcb_sel_e'(alu_src_b_i))
      SRCB_REG:    alu_opb = b_q;
      SRCB_FOUR:   alu_opb = DATA_W'(4);
      SRCB_IMM:    alu_opb = imm_ext;
      SRCB_IMM_SH: alu_opb = imm_sh;
      default:     alu_opb = '0;
    endcase
  end

  mc_alu #(.DATA_W(DATA_W)) u_alu (
    .opa_i (alu_opa),
    .opb_i (alu_opb),
    .op_i  (alu_op_e'(alu_op_i)),
    .res_o (alu_res),
    .zero_o(zero_o)
  );

  // shared memory
  assign mem_addr = iord_i ? aluout_q : pc_q;

  mc_unified_mem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk_i    (clk_i),
    .idx_i    (mem_addr[BYTE_OFS +: MEM_AW]),
    .re_i     (mem_read_i),
    .we_i     (mem_write_i),
    .wd_i     (b_q),
    .ld_en_i  (load_en_i),
    .ld_idx_i (load_addr_i),
    .ld_data_i(load_data_i),
    .rdata_o  (mem_rdata)
  );

  // register file
  assign rf_wa = reg_dst_i ? rd_idx : rt_idx;
  assign rf_wd = mem_to_reg_i ? mdr_q : aluout_q;

  mc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra1_i (rs_idx),
    .ra2_i (rt_idx),
    .ra3_i (dbg_reg_sel_i),
    .rd1_o (rf_rd1),
    .rd2_o (rf_rd2),
    .rd3_o (dbg_reg_data_o),
    .we_i  (reg_write_i),
    .wa_i  (rf_wa),
    .wd_i  (rf_wd)
  );

  // architectural and holding registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_write_i) pc_q <= pc_source_i ? aluout_q : alu_res;
      if (ir_write_i) ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rf_rd1;
      b_q      <= rf_rd2;
      aluout_q <= alu_res;
    end
  end

  assign pc_o     = pc_q;
  assign opcode_o = ir_q[OPC_LSB +: FLD_W];
  assign funct_o  = ir_q[FLD_W-1:0];

  assign unused_bits = ^{mem_addr[DATA_W-1:BYTE_OFS+MEM_AW], mem_addr[BYTE_OFS-1:0],
                         ir_q[RD_LSB-1:FLD_W]};

  assert_pc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_write_i |=> $stable(pc_q));

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_i && !pc_source_i) |=> pc_q == $past(alu_res));

  assert_pc_branch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_i && pc_source_i) |=> pc_q == $past(aluout_q));

  assert_ir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_write_i |=> $stable(ir_q));

  assert_mdr_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_read_i |=> mdr_q == '0);

  assert_sub_equal_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i == 2'b01 && alu_opa == alu_opb) |-> zero_o);
endmodule

// File: tb/mc_datapath_bench.sv
`timescale 1ns/1ps
module mc_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pc_write, pc_source, ir_write, iord, mem_read, mem_write;
  logic        alu_src_a, reg_dst, mem_to_reg, reg_write, load_en;
  logic [1:0]  alu_src_b, alu_op;
  logic [7:0]  load_addr;
  logic [31:0] load_data;
  logic [4:0]  dbg_sel;
  logic [5:0]  opcode, funct;
  logic        zero;
  logic [31:0] pc, dbg_data;

  logic [31:0] reg_m [32];
  logic [31:0] mem_m [256];
  logic [31:0] pc_m;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 0;

  always #5 clk = ~clk;

  mc_datapath u_mc_datapath (
    .clk_i(clk), .rst_ni(rst_n),
    .pc_write_i(pc_write), .pc_source_i(pc_source), .ir_write_i(ir_write),
    .iord_i(iord), .mem_read_i(mem_read), .mem_write_i(mem_write),
    .alu_src_a_i(alu_src_a), .alu_src_b_i(alu_src_b), .alu_op_i(alu_op),
    .reg_dst_i(reg_dst), .mem_to_reg_i(mem_to_reg), .reg_write_i(reg_write),
    .load_en_i(load_en), .load_addr_i(load_addr), .load_data_i(load_data),
    .dbg_reg_sel_i(dbg_sel),
    .opcode_o(opcode), .funct_o(funct), .zero_o(zero),
    .pc_o(pc), .dbg_reg_data_o(dbg_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic idle();
    pc_write = 0; pc_source = 0; ir_write = 0; iord = 0; mem_read = 0; mem_write = 0;
    alu_src_a = 0; alu_src_b = 2'b00; alu_op = 2'b00; reg_dst = 0; mem_to_reg = 0;
    reg_write = 0; load_en = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic preload(input logic [7:0] idx, input logic [31:0] data);
    idle();
    load_en = 1; load_addr = idx; load_data = data;
    tick();
    load_en = 0;
    mem_m[idx] = data;
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < 32; r++) begin
      dbg_sel = 5'(r);
      #1;
      chk(dbg_data == reg_m[r], tag, dbg_data, reg_m[r]);
    end
  endtask

  // fetch + decode common to every instruction
  task automatic fetch_decode(input logic [31:0] instr);
    preload(8'(pc_m >> 2), instr);
    mem_read = 1; iord = 0; ir_write = 1;
    alu_src_a = 0; alu_src_b = 2'b01; alu_op = 2'b00; pc_source = 0; pc_write = 1;
    tick();
    idle();
    pc_m = pc_m + 4;
    chk(pc == pc_m, "R2 pc+4 on fetch", pc, pc_m);
    chk(opcode == instr[31:26], "R3 opcode field", 32'(opcode), 32'(instr[31:26]));
    chk(funct == instr[5:0], "R3 funct field", 32'(funct), 32'(instr[5:0]));
    alu_src_a = 0; alu_src_b = 2'b11; alu_op = 2'b00;  // branch target into result latch
    tick();
    idle();
  endtask

  task automatic do_rtype(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd,
                          input logic [1:0] op);
    logic [31:0] instr, exp;
    logic [5:0]  fn;
    fn = (op == 2'b00) ? 6'h20 : (op == 2'b01) ? 6'h22 : (op == 2'b10) ? 6'h24 : 6'h25;
    instr = {6'h00, rs, rt, rd, 5'h00, fn};
    case (op)
      2'b00:   exp = reg_m[rs] + reg_m[rt];
      2'b01:   exp = reg_m[rs] - reg_m[rt];
      2'b10:   exp = reg_m[rs] & reg_m[rt];
      default: exp = reg_m[rs] | reg_m[rt];
    endcase
    fetch_decode(instr);
    alu_src_a = 1; alu_src_b = 2'b00; alu_op = op;
    #1;
    chk(zero == (exp == 32'h0), "R5 zero flag on arithmetic", 32'(zero), 32'(exp == 32'h0));
    tick();
    idle();
    reg_dst = 1; mem_to_reg = 0; reg_write = 1;
    dbg_sel = rd;
    #1;
    chk(dbg_data == reg_m[rd], "R12 old value during write cycle", dbg_data, reg_m[rd]);
    tick();
    idle();
    if (rd != 0) reg_m[rd] = exp;
    chk(opcode == 6'h00, "R3 instruction held", 32'(opcode), 32'h0);
    check_regs("R10 R11 R4 R6 rtype register state");
  endtask

  task automatic do_load(input logic [4:0] rt, input logic [15:0] imm);
    logic [31:0] addr;
    fetch_decode({6'h23, 5'd0, rt, imm});
    addr = sext(imm);
    alu_src_a = 1; alu_src_b = 2'b10; alu_op = 2'b00;
    tick();
    idle();
    iord = 1; mem_read = 1;
    tick();
    idle();
    reg_dst = 0; mem_to_reg = 1; reg_write = 1;
    tick();
    idle();
    if (rt != 0) reg_m[rt] = mem_m[(addr >> 2) & 32'hFF];
    check_regs("R7 R10 load register state");
  endtask

  task automatic do_store(input logic [4:0] rt, input logic [15:0] imm);
    logic [31:0] addr;
    fetch_decode({6'h2B, 5'd0, rt, imm});
    addr = sext(imm);
    alu_src_a = 1; alu_src_b = 2'b10; alu_op = 2'b00;
    tick();
    idle();
    iord = 1; mem_write = 1;
    tick();
    idle();
    mem_m[(addr >> 2) & 32'hFF] = reg_m[rt];
    check_regs("R8 store leaves registers");
  endtask

  task automatic do_branch(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off);
    bit taken;
    fetch_decode({6'h04, rs, rt, off});
    taken = (reg_m[rs] == reg_m[rt]);
    alu_src_a = 1; alu_src_b = 2'b00; alu_op = 2'b01; pc_source = 1; pc_write = taken;
    #1;
    chk(zero == taken, "R5 zero on compare", 32'(zero), 32'(taken));
    tick();
    idle();
    if (taken) pc_m = pc_m + (sext(off) << 2);
    chk(pc == pc_m, "R2 R4 branch pc", pc, pc_m);
  endtask

  initial begin
    idle();
    dbg_sel = 0; load_addr = 0; load_data = 0;
    rst_n = 0;
    for (int r = 0; r < 32; r++) reg_m[r] = 0;
    pc_m = 0;
    repeat (3) @(negedge clk);
    check_regs("R1 registers in reset");
    chk(pc == 0, "R1 pc in reset", pc, 0);
    rst_n = 1;
    tick();
    chk(pc == 0, "R1 pc after reset", pc, 0);
    chk(opcode == 0 && funct == 0, "R1 ir after reset", {20'h0, opcode, funct}, 0);

    // data region: words 128..255
    for (int w = 128; w < 256; w++) preload(8'(w), $urandom());

    for (int r = 1; r < 32; r++) do_load(5'(r), 16'(16'h0200 + 4 * r));
    // negative offset wraps to word 255 (R7)
    do_load(5'd7, 16'hFFFC);
    // write to register 0 is dropped (R11)
    do_rtype(5'd1, 5'd2, 5'd0, 2'b00);

    for (int n = 0; n < 320; n++) begin
      int unsigned kind, k;
      logic [4:0]  a, b;
      kind = $urandom % 8;
      a = 5'($urandom % 32);
      b = 5'($urandom % 32);
      k = $urandom % 128;
      if ((pc_m >> 2) >= 118) begin
        do_branch(5'd0, 5'd0, 16'(-int'((pc_m + 4) >> 2)));
      end else if (kind < 4) begin
        do_rtype(a, b, 5'($urandom % 32), 2'(kind));
      end else if (kind == 4) begin
        do_load(b, ($urandom % 2) ? 16'(16'h0200 + 4 * k) : 16'(16'hFFFC - 4 * k));
      end else if (kind == 5) begin
        logic [15:0] imm;
        imm = ($urandom % 2) ? 16'(16'h0200 + 4 * k) : 16'(16'hFFFC - 4 * k);
        do_store(b, imm);
        do_load(5'($urandom % 32), imm);
      end else begin
        int off;
        off = int'($urandom % 7) - 3;
        if ((pc_m >> 2) + 1 + off < 0 || (pc_m >> 2) + 1 + off > 117) off = 0;
        do_branch(a, ($urandom % 3 == 0) ? a : b, 16'(off));
      end
    end

    // read gate: IR loads zero when mem_read is low, pc held without enable
    pc_m = pc;
    idle();
    ir_write = 1; mem_read = 0;
    tick();
    idle();
    chk(opcode == 0 && funct == 0, "R9 gated read loads zero", {20'h0, opcode, funct}, 0);
    chk(pc == pc_m, "R2 pc holds without enable", pc, pc_m);
    report();
  end

  initial begin
    #2_000_000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", pc, pc_m);
    report();
  end
endmodule